// File: doc/BRIEF.md
# UART Baud Divisor and Line Settings Register Block

This block holds the baud-rate divisors, the line-settings byte and the control word of a UART, and turns them into signals for the serial paths. A host reaches it through a small register port: a byte address, write data with a write strobe, and combinational read data. From the divisors it makes a one-cycle tick at sixteen times the bit rate. The integer part counts whole reference clocks. A 6-bit fraction (fractional part times 64, rounded) is accumulated so that the average tick period equals integer + fraction/64 clocks. The integer divisor is the reference clock divided by sixteen times the baud rate.

The two divisor registers do not act on their own. A write to either of them is held in a pending copy. That copy moves into the tick generator only when the line-settings register is written. As a result, the divisors and the line format always change together. The line-settings byte is decoded into word length, parity, stop-bit and FIFO controls for the transmit and receive paths. A change of the FIFO-enable bit produces a flush pulse. The send-break bit forces the serial output low.

Top module: `uart_line_regs`

## Requirements
- R1: Registers sit at byte offsets 0x24 (integer divisor, 16 bits), 0x28 (fractional divisor, bits 5:0), 0x2C (line settings, bits 7:0) and 0x30 (control). Each reads back the last value written to it, with undefined bits read as zero. Any other offset reads zero and ignores writes.
- R2: A write to either divisor does not change the tick rate. The pending divisors become active on the next write to line settings. A divisor readback returns the pending value.
- R3: Line-settings fields are decoded as follows: bit 0 send break, bit 1 parity enable, bit 2 even parity, bit 3 two stop bits, bit 4 FIFO enable, bits 6:5 word-length code (00=5 through 11=8 bits), bit 7 stick parity. Each field drives its output from the cycle after the write.
- R4: With active integer divisor I>0 and fraction F, the average spacing of baud ticks is I+F/64 clocks. With F=0, the ticks are exactly I clocks apart, and I=1 gives a tick every clock.
- R5: A write to line settings that changes the FIFO-enable bit gives a fifoFlush pulse of exactly one cycle. A write that leaves the bit unchanged gives no pulse.
- R6: The control register keeps only bits 0 (enable), 7, 8, 9, 11, 14 and 15, and all other bits read zero. No baud tick is produced while control bit 0 is clear.
- R7: An active integer divisor of zero stops the baud tick.
- R8: While send break is set, txOut is low. Otherwise txOut equals txIn.
- R9: After reset, all registers read zero, all decoded outputs are low, no tick is produced and txOut follows txIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 16 | Write data |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| txIn | input | 1 | Serial data from the transmit shifter |
| txOut | output | 1 | Serial line output, low during break |
| baudTick | output | 1 | One-cycle tick at 16x bit rate |
| wordLenCode | output | 2 | Word length code, 00=5 to 11=8 bits |
| parityEn | output | 1 | Parity enabled |
| parityEven | output | 1 | Even parity selected |
| stickParity | output | 1 | Stick parity selected |
| twoStop | output | 1 | Two stop bits |
| sendBreak | output | 1 | Break being sent |
| fifoEn | output | 1 | FIFOs enabled |
| fifoFlush | output | 1 | One-cycle flush pulse on FIFO-enable change |

## Verification
Some properties are checked by assertions on every cycle. The active divisors stay still between line-settings writes. No more than one register strobe fires at a time. A flush pulse only follows a line-settings write. No tick follows a zero divisor or a cleared enable. The line stays low during break. The bench scenarios cover what a single cycle cannot show. They measure average tick spacing over long windows, including fractional divisors. They confirm that a divisor write alone leaves the rate unchanged until line settings are written. They also check readback masking and the full decoding of line-setting fields.

// File: rtl/uart_lcr_pkg.sv
package uart_lcr_pkg;
  localparam logic [7:0] OFF_IDIV = 8'h24;
  localparam logic [7:0] OFF_FDIV = 8'h28;
  localparam logic [7:0] OFF_LINE = 8'h2C;
  localparam logic [7:0] OFF_CTRL = 8'h30;

  localparam int LINE_W      = 8;
  localparam int BIT_BREAK   = 0;
  localparam int BIT_PAREN   = 1;
  localparam int BIT_PAREVEN = 2;
  localparam int BIT_TWOSTOP = 3;
  localparam int BIT_FIFOEN  = 4;
  localparam int BIT_WLEN_LO = 5;
  localparam int BIT_STICK   = 7;
  localparam int BIT_ENABLE  = 0;

  localparam logic [15:0] CTRL_KEEP = 16'hCB81;

  typedef struct packed {
    logic wrIdiv;
    logic wrFdiv;
    logic wrLine;
    logic wrCtrl;
  } regStrobe_t;
endpackage

// File: rtl/uart_lcr_ctrl.sv
module uart_lcr_ctrl
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [INT_W-1:0]  pendInt,
  input  logic [FRAC_W-1:0] pendFrac,
  input  logic [LINE_W-1:0] lineReg,
  input  logic [DATA_W-1:0] ctrlReg,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] A_IDIV = ADDR_W'(OFF_IDIV);
  localparam logic [ADDR_W-1:0] A_FDIV = ADDR_W'(OFF_FDIV);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      strobe.wrIdiv = (regAddr == A_IDIV);
      strobe.wrFdiv = (regAddr == A_FDIV);
      strobe.wrLine = (regAddr == A_LINE);
      strobe.wrCtrl = (regAddr == A_CTRL);
    end
  end

  always_comb begin
    case (regAddr)
      A_IDIV:  regRdData = DATA_W'(pendInt);
      A_FDIV:  regRdData = DATA_W'(pendFrac);
      A_LINE:  regRdData = DATA_W'(lineReg);
      A_CTRL:  regRdData = ctrlReg;
      default: regRdData = '0;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("two register strobes at once"); // R1
endmodule

// File: rtl/uart_lcr_datapath.sv
module uart_lcr_datapath
  import uart_lcr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [INT_W-1:0]  pendInt,
  output logic [FRAC_W-1:0] pendFrac,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac,
  output logic [LINE_W-1:0] lineReg,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              loadPulse,
  output logic              flushPulse
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendInt    <= '0;
      pendFrac   <= '0;
      activeInt  <= '0;
      activeFrac <= '0;
      lineReg    <= '0;
      ctrlReg    <= '0;
      loadPulse  <= 1'b0;
      flushPulse <= 1'b0;
    end else begin
      loadPulse  <= strobe.wrLine;
      flushPulse <= strobe.wrLine && (wrData[BIT_FIFOEN] != lineReg[BIT_FIFOEN]);
      if (strobe.wrIdiv) pendInt  <= wrData[INT_W-1:0];
      if (strobe.wrFdiv) pendFrac <= wrData[FRAC_W-1:0];
      if (strobe.wrCtrl) ctrlReg  <= wrData & KEEP;
      if (strobe.wrLine) begin
        lineReg    <= wrData[LINE_W-1:0];
        activeInt  <= pendInt;
        activeFrac <= pendFrac;
      end
    end
  end

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrLine) |-> ($stable(activeInt) && $stable(activeFrac)))
    else $error("active divisor moved without line write"); // R2
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(strobe.wrLine)) else $error("flush without line write"); // R5
  AST_FLUSH_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> !$past(flushPulse) || $past(strobe.wrLine, 2))
    else $error("flush longer than a cycle"); // R5
endmodule

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              restart,
  input  logic [INT_W-1:0]  intDiv,
  input  logic [FRAC_W-1:0] fracDiv,
  output logic              tick
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  curPeriod;
  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic              active;

  assign fracSum = {1'b0, fracAcc} + {1'b0, fracDiv};
  assign active  = run && (intDiv != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      curPeriod <= '0;
      fracAcc   <= '0;
      tick      <= 1'b0;
    end else if (restart) begin
      count     <= '0;
      curPeriod <= CNT_W'(intDiv);
      fracAcc   <= '0;
      tick      <= 1'b0;
    end else if (!active) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == curPeriod - 1'b1) begin
      count     <= '0;
      fracAcc   <= fracSum[FRAC_W-1:0];
      curPeriod <= CNT_W'(intDiv) + CNT_W'(fracSum[FRAC_W]);
      tick      <= 1'b1;
    end else begin
      count <= count + 1'b1;
      tick  <= 1'b0;
    end
  end

  AST_NO_TICK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(intDiv) != '0) else $error("tick with zero divisor"); // R7
  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(run)) else $error("tick while disabled"); // R6
endmodule

// File: rtl/uart_line_regs.sv
module uart_line_regs
  import uart_lcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txIn,
  output logic              txOut,
  output logic              baudTick,
  output logic [1:0]        wordLenCode,
  output logic              parityEn,
  output logic              parityEven,
  output logic              stickParity,
  output logic              twoStop,
  output logic              sendBreak,
  output logic              fifoEn,
  output logic              fifoFlush
);
  regStrobe_t        strobe;
  logic [INT_W-1:0]  pendInt, activeInt;
  logic [FRAC_W-1:0] pendFrac, activeFrac;
  logic [LINE_W-1:0] lineReg;
  logic [DATA_W-1:0] ctrlReg;
  logic              loadPulse;

  uart_lcr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .pendInt(pendInt), .pendFrac(pendFrac), .lineReg(lineReg), .ctrlReg(ctrlReg),
    .strobe(strobe), .regRdData(regRdData));

  uart_lcr_datapath #(.DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .pendInt(pendInt), .pendFrac(pendFrac), .activeInt(activeInt), .activeFrac(activeFrac),
    .lineReg(lineReg), .ctrlReg(ctrlReg), .loadPulse(loadPulse), .flushPulse(fifoFlush));

  uart_baud_tick #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uTick (
    .clk(clk), .rstN(rstN), .run(ctrlReg[BIT_ENABLE]), .restart(loadPulse),
    .intDiv(activeInt), .fracDiv(activeFrac), .tick(baudTick));

  assign sendBreak   = lineReg[BIT_BREAK];
  assign parityEn    = lineReg[BIT_PAREN];
  assign parityEven  = lineReg[BIT_PAREVEN];
  assign twoStop     = lineReg[BIT_TWOSTOP];
  assign fifoEn      = lineReg[BIT_FIFOEN];
  assign wordLenCode = lineReg[BIT_WLEN_LO +: 2];
  assign stickParity = lineReg[BIT_STICK];
  assign txOut       = txIn && !sendBreak;

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txOut) else $error("line not low in break"); // R8
endmodule

// File: tb/uart_line_regs_test.sv
`timescale 1ns/1ps
module uart_line_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regRdData;
  logic        txIn = 1'b1;
  logic        txOut, baudTick;
  logic [1:0]  wordLenCode;
  logic        parityEn, parityEven, stickParity, twoStop, sendBreak, fifoEn, fifoFlush;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_line_regs uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic countTicks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (baudTick) n++;
    end
  endtask

  task automatic checkNear(input int act, input int exp, input string req);
    check(act >= exp - 1 && act <= exp + 1, req, act, exp);
  endtask

  task automatic testReset;
    logic [15:0] d; int n;
    readReg(8'h24, d); check(d == 0, "R9 idiv", d, 0);
    readReg(8'h2C, d); check(d == 0, "R9 line", d, 0);
    readReg(8'h30, d); check(d == 0, "R9 ctrl", d, 0);
    check({wordLenCode, parityEn, parityEven, stickParity, twoStop, sendBreak, fifoEn, fifoFlush} == 0,
          "R9 outputs", 1, 0);
    txIn = 1'b1; #1 check(txOut == 1'b1, "R9 txOut", txOut, 1);
    countTicks(40, n); check(n == 0, "R9 ticks", n, 0);
  endtask

  task automatic testRegMap;
    logic [15:0] d;
    writeReg(8'h24, 16'hBEEF); readReg(8'h24, d); check(d == 16'hBEEF, "R1 idiv", d, 16'hBEEF);
    writeReg(8'h28, 16'hFFFF); readReg(8'h28, d); check(d == 16'h003F, "R1 fdiv", d, 16'h3F);
    writeReg(8'h30, 16'hFFFF); readReg(8'h30, d); check(d == 16'hCB81, "R6 ctrl mask", d, 16'hCB81);
    writeReg(8'h34, 16'h1234); readReg(8'h34, d); check(d == 0, "R1 unmapped", d, 0);
    readReg(8'h24, d); check(d == 16'hBEEF, "R1 unmapped write ignored", d, 16'hBEEF);
    writeReg(8'h28, 16'h0000);
  endtask

  task automatic testLineFields;
    logic [15:0] d;
    writeReg(8'h2C, 16'h00E9);
    check(sendBreak == 1 && parityEn == 0 && parityEven == 0 && twoStop == 1 &&
          fifoEn == 0 && wordLenCode == 2'b11 && stickParity == 1, "R3 fields E9", 0, 1);
    readReg(8'h2C, d); check(d == 16'h00E9, "R1 line readback", d, 16'hE9);
    writeReg(8'h2C, 16'h0056);
    check(sendBreak == 0 && parityEn == 1 && parityEven == 1 && twoStop == 0 &&
          fifoEn == 1 && wordLenCode == 2'b10 && stickParity == 0, "R3 fields 56", 0, 1);
    writeReg(8'h2C, 16'h0000);
  endtask

  task automatic testHold;
    int n; logic [15:0] d;
    writeReg(8'h30, 16'h0301);
    writeReg(8'h24, 16'd4); writeReg(8'h28, 16'd0); writeReg(8'h2C, 16'h0060);
    countTicks(400, n); checkNear(n, 100, "R4 divisor 4");
    writeReg(8'h24, 16'd8);
    countTicks(400, n); checkNear(n, 100, "R2 rate held");
    readReg(8'h24, d); check(d == 8, "R2 pending readback", d, 8);
    writeReg(8'h2C, 16'h0060);
    countTicks(400, n); checkNear(n, 50, "R2 rate after line write");
  endtask

  task automatic testFraction;
    int n;
    writeReg(8'h24, 16'd3); writeReg(8'h28, 16'd16); writeReg(8'h2C, 16'h0060);
    countTicks(650, n); checkNear(n, 200, "R4 fraction 3.25");
    writeReg(8'h24, 16'd1); writeReg(8'h28, 16'd0); writeReg(8'h2C, 16'h0060);
    countTicks(100, n); checkNear(n, 100, "R4 divisor 1");
  endtask

  task automatic testZeroAndEnable;
    int n;
    writeReg(8'h24, 16'd0); writeReg(8'h2C, 16'h0060);
    countTicks(100, n); check(n == 0, "R7 zero divisor", n, 0);
    writeReg(8'h24, 16'd4); writeReg(8'h2C, 16'h0060);
    writeReg(8'h30, 16'h0300);
    countTicks(100, n); check(n == 0, "R6 disabled", n, 0);
    writeReg(8'h30, 16'h0001);
    countTicks(400, n); checkNear(n, 100, "R6 re-enabled");
  endtask

  task automatic testFlush;
    writeReg(8'h2C, 16'h0070);
    check(fifoFlush == 1, "R5 flush on set", fifoFlush, 1);
    @(negedge clk); check(fifoFlush == 0, "R5 flush one cycle", fifoFlush, 0);
    writeReg(8'h2C, 16'h0071);
    check(fifoFlush == 0, "R5 no flush unchanged", fifoFlush, 0);
    writeReg(8'h2C, 16'h0060);
    check(fifoFlush == 1, "R5 flush on clear", fifoFlush, 1);
  endtask

  task automatic testBreak;
    txIn = 1'b1;
    writeReg(8'h2C, 16'h0061);
    #1 check(txOut == 0, "R8 break low", txOut, 0);
    txIn = 1'b0; #1 check(txOut == 0, "R8 break low data0", txOut, 0);
    writeReg(8'h2C, 16'h0060);
    txIn = 1'b1; #1 check(txOut == 1, "R8 pass 1", txOut, 1);
    txIn = 1'b0; #1 check(txOut == 0, "R8 pass 0", txOut, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testLineFields();
    testHold();
    testFraction();
    testZeroAndEnable();
    testFlush();
    testBreak();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule